// File: doc/BRIEF.md
# Pixel Event Capture Controller

This block is the digital control for one pixel of a calorimeter readout chip. It runs on a fast system clock, and a one-cycle bunch strobe marks each beam crossing. A 12-bit bunch counter gives the crossing number. When the event comparator output rises while the pixel is armed, the block stores that crossing number in the next free buffer slot, together with a range bit taken from the range comparator. It then runs a fixed sequence on the analog control lines. Track opens after a settling delay. The sample is held once a fixed time has passed since the trigger. After the hold, the controller waits for the next bunch strobe and then clamps both feedback capacitors before it re-arms.

While the pixel is idle, the high-gain reset pulses once for every crossing, and it stays low while an event is being processed. The low-gain reset is driven only at power-up and after each event. Four slots are held per train. A train-start pulse empties them and restarts the bunch count. Any trigger that arrives after the slots are full leaves a sticky overflow mark.

Top module: `pixel_capture`

## Requirements
- R1: While reset is high, `lg_reset` and `hg_reset` are 1 and `track`, `armed`, `evt_count`, `ovf` and `slot_valid` are 0. After reset is released, `lg_reset` stays 1 for RESET_LEN cycles, and then `armed` rises.
- R2: The bunch counter starts at 0 after a train start and adds one on every bunch strobe. It stops at 4095 and does not wrap. The stamp stored for a trigger is the count as it stood before any increment made in the trigger cycle.
- R3: A 0-to-1 step on `event_cmp` while `armed` is 1 and the slots are not full is a trigger. It fills slots in the order 0, 1, 2, 3 (slot k is bits 12k+11..12k of `slot_stamp`, bit k of `slot_valid` and bit k of `slot_range`), sets that slot's valid bit and adds one to `evt_count`.
- R4: The slot's range bit is 1 if `range_cmp` is 1 in the trigger cycle or in any of the RANGE_WIN cycles after it. A `range_cmp` pulse that comes later has no effect on the bit.
- R5: `track` rises TRACK_DLY cycles after the trigger edge and falls HOLD_DLY cycles after it.
- R6: While the pixel is armed, `hg_reset` is 1 for exactly the one cycle after each bunch strobe. No pulse follows a strobe that falls in the trigger cycle, and none follows a strobe while an event is in progress.
- R7: After the hold, `lg_reset` stays 0 until the next bunch strobe. It is then 1, together with `hg_reset`, for RESET_LEN cycles, and after that `armed` returns to 1.
- R8: Rising edges on `event_cmp` while `armed` is 0 have no effect: they are not counted and nothing is stored.
- R9: A trigger that arrives while all four slots are valid does not start a sequence and changes no slot. It sets `ovf`, which then stays set, and it still adds one to `evt_count`.
- R10: A train-start pulse clears the bunch counter, the slot pointer, all valid bits, `evt_count` and `ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | One-cycle pulse at the start of a bunch train |
| bunch_strobe | input | 1 | One-cycle pulse for each beam crossing |
| event_cmp | input | 1 | Event comparator output |
| range_cmp | input | 1 | Range comparator output |
| hg_reset | output | 1 | High-gain feedback capacitor reset |
| lg_reset | output | 1 | Low-gain capacitor reset |
| track | output | 1 | Sample capacitor connected to amplifier |
| armed | output | 1 | Pixel ready for a new trigger |
| evt_count | output | 5 | Accepted trigger edges in this train |
| ovf | output | 1 | Sticky flag: a trigger came with all slots full |
| slot_valid | output | 4 | Per-slot valid bits |
| slot_range | output | 4 | Per-slot range bits |
| slot_stamp | output | 48 | Per-slot 12-bit crossing stamps, slot 0 in the low bits |

## Verification
A bunch strobe and a trigger edge can fall in the same cycle. In that cycle the bunch counter advances, a slot captures the stamp and the high-gain reset pulse decision is made, all at once. The bench provokes this by raising `event_cmp` and `bunch_strobe` together in an idle cycle. It judges the result on three points: the stored stamp must be the count before the increment, `hg_reset` must stay low in the following cycle, and the next plain trigger must see the advanced count.

// File: rtl/pix_pkg.sv
package pix_pkg;

    localparam int STAMP_W = 12;
    localparam int CNT_W   = 5;

    typedef enum logic [1:0] {
        S_IDLE,
        S_EVENT,
        S_WAIT_BX,
        S_RECOVER
    } seq_state_e;

    typedef struct packed {
        logic               valid;
        logic               rng;
        logic [STAMP_W-1:0] stamp;
    } slot_t;

    function automatic logic [STAMP_W-1:0] stamp_sat_inc(input logic [STAMP_W-1:0] v);
        return (v == {STAMP_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/pix_bunch_timer.sv
module pix_bunch_timer
    import pix_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               strobe,
    output logic [STAMP_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (strobe) begin
            count <= stamp_sat_inc(count);
        end
    end

    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (count == {STAMP_W{1'b1}} && !clear) |=> (count == {STAMP_W{1'b1}}));

    a_r10_clear_count: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0));

endmodule

// File: rtl/pix_sequencer.sv
module pix_sequencer
    import pix_pkg::*;
#(
    parameter int TRACK_DLY = 8,
    parameter int HOLD_DLY  = 50,
    parameter int RANGE_WIN = 5,
    parameter int RESET_LEN = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic bunch_strobe,
    output logic armed,
    output logic track,
    output logic lg_reset,
    output logic hg_pulse,
    output logic range_open
);

    localparam int TMAX  = (HOLD_DLY > RESET_LEN) ? HOLD_DLY : RESET_LEN;
    localparam int TMR_W = $clog2(TMAX + 1);

    seq_state_e       state;
    logic [TMR_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_RECOVER;
            tmr      <= '0;
            hg_pulse <= 1'b0;
        end else begin
            hg_pulse <= bunch_strobe && (state == S_IDLE) && !trig;
            case (state)
                S_IDLE: begin
                    if (trig) begin
                        state <= S_EVENT;
                        tmr   <= '0;
                    end
                end
                S_EVENT: begin
                    if (tmr == TMR_W'(HOLD_DLY - 1)) begin
                        state <= S_WAIT_BX;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                S_WAIT_BX: begin
                    if (bunch_strobe) begin
                        state <= S_RECOVER;
                        tmr   <= '0;
                    end
                end
                default: begin
                    if (tmr == TMR_W'(RESET_LEN - 1)) begin
                        state <= S_IDLE;
                        tmr   <= '0;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        armed      = (state == S_IDLE);
        track      = (state == S_EVENT) && (tmr >= TMR_W'(TRACK_DLY));
        lg_reset   = (state == S_RECOVER);
        range_open = (state == S_EVENT) && (tmr < TMR_W'(RANGE_WIN));
    end

    a_r3_enter_event: assert property (@(posedge clk) disable iff (rst)
        (armed && trig) |=> (state == S_EVENT && tmr == '0));

    a_r7_recover_after_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(lg_reset) |-> $past(bunch_strobe));

endmodule

// File: rtl/pix_slot_bank.sv
module pix_slot_bank
    import pix_pkg::*;
#(
    parameter int NSLOT = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     wr,
    input  logic [STAMP_W-1:0]       stamp_in,
    input  logic                     rng_in,
    input  logic                     rng_set,
    output logic                     full,
    output logic [NSLOT-1:0]         valid,
    output logic [NSLOT-1:0]         rng,
    output logic [NSLOT*STAMP_W-1:0] stamps
);

    localparam int PTR_W = $clog2(NSLOT + 1);

    logic [PTR_W-1:0] ptr;
    slot_t            slots [NSLOT];

    assign full = (ptr == PTR_W'(NSLOT));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (wr && !full) begin
            ptr <= ptr + 1'b1;
        end
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '0;
            end else if (clear) begin
                slots[i].valid <= 1'b0;
            end else if (wr && ptr == PTR_W'(i)) begin
                slots[i].valid <= 1'b1;
                slots[i].rng   <= rng_in;
                slots[i].stamp <= stamp_in;
            end else if (rng_set && ptr == PTR_W'(i + 1)) begin
                slots[i].rng <= 1'b1;
            end
        end
        assign valid[i] = slots[i].valid;
        assign rng[i]   = slots[i].rng;
        assign stamps[i*STAMP_W +: STAMP_W] = slots[i].stamp;
    end

    a_r9_ptr_bound: assert property (@(posedge clk) disable iff (rst)
        ptr <= PTR_W'(NSLOT));

    a_r9_no_write_full: assert property (@(posedge clk) disable iff (rst)
        wr |-> !full);

endmodule

// File: rtl/pixel_capture.sv
module pixel_capture
    import pix_pkg::*;
#(
    parameter int NSLOT     = 4,
    parameter int TRACK_DLY = 8,
    parameter int HOLD_DLY  = 50,
    parameter int RANGE_WIN = 5,
    parameter int RESET_LEN = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     train_start,
    input  logic                     bunch_strobe,
    input  logic                     event_cmp,
    input  logic                     range_cmp,
    output logic                     hg_reset,
    output logic                     lg_reset,
    output logic                     track,
    output logic                     armed,
    output logic [CNT_W-1:0]         evt_count,
    output logic                     ovf,
    output logic [NSLOT-1:0]         slot_valid,
    output logic [NSLOT-1:0]         slot_range,
    output logic [NSLOT*STAMP_W-1:0] slot_stamp
);

    logic               evt_q;
    logic               rise;
    logic               qual;
    logic               trig;
    logic               full;
    logic               hg_pulse;
    logic               range_open;
    logic [STAMP_W-1:0] bunch_cnt;

    assign rise = event_cmp && !evt_q;
    assign qual = rise && armed && !train_start;
    assign trig = qual && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= event_cmp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || train_start) begin
            evt_count <= '0;
            ovf       <= 1'b0;
        end else if (qual) begin
            evt_count <= cnt_sat_inc(evt_count);
            if (full) begin
                ovf <= 1'b1;
            end
        end
    end

    pix_bunch_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .clear  (train_start),
        .strobe (bunch_strobe),
        .count  (bunch_cnt)
    );

    pix_sequencer #(
        .TRACK_DLY (TRACK_DLY),
        .HOLD_DLY  (HOLD_DLY),
        .RANGE_WIN (RANGE_WIN),
        .RESET_LEN (RESET_LEN)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .trig         (trig),
        .bunch_strobe (bunch_strobe),
        .armed        (armed),
        .track        (track),
        .lg_reset     (lg_reset),
        .hg_pulse     (hg_pulse),
        .range_open   (range_open)
    );

    pix_slot_bank #(
        .NSLOT (NSLOT)
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .clear    (train_start),
        .wr       (trig),
        .stamp_in (bunch_cnt),
        .rng_in   (range_cmp),
        .rng_set  (range_open && range_cmp),
        .full     (full),
        .valid    (slot_valid),
        .rng      (slot_range),
        .stamps   (slot_stamp)
    );

    assign hg_reset = hg_pulse || lg_reset;

    a_r5_track_not_armed: assert property (@(posedge clk) disable iff (rst)
        track |-> (!armed && !lg_reset));

    a_r6_hg_after_strobe: assert property (@(posedge clk) disable iff (rst)
        (hg_reset && !lg_reset) |-> $past(bunch_strobe));

    a_r8_busy_no_count: assert property (@(posedge clk) disable iff (rst)
        (!armed && !train_start) |=> $stable(evt_count));

    a_r10_clear_flags: assert property (@(posedge clk) disable iff (rst)
        train_start |=> (evt_count == '0 && !ovf && slot_valid == '0));

endmodule

// File: tb/sim_pixel_capture.sv
module sim_pixel_capture;

    localparam int TRK = 8;
    localparam int HLD = 50;
    localparam int RW  = 5;
    localparam int RL  = 10;
    localparam int NS  = 4;

    typedef struct {
        int          idx;
        logic [11:0] stamp;
        logic        rng;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        train_start = 1'b0;
    logic        bunch_strobe = 1'b0;
    logic        event_cmp = 1'b0;
    logic        range_cmp = 1'b0;
    logic        hg_reset, lg_reset, track, armed, ovf;
    logic [4:0]  evt_count;
    logic [3:0]  slot_valid, slot_range;
    logic [47:0] slot_stamp;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    int   bc     = 0;
    int   exp_cnt = 0;
    int   exp_idx = 0;
    exp_t sb_q[$];
    logic trk_prev = 1'b0;

    always #10 clk = ~clk;

    pixel_capture #(
        .NSLOT(NS), .TRACK_DLY(TRK), .HOLD_DLY(HLD), .RANGE_WIN(RW), .RESET_LEN(RL)
    ) u0 (
        .clk(clk), .rst(rst), .train_start(train_start), .bunch_strobe(bunch_strobe),
        .event_cmp(event_cmp), .range_cmp(range_cmp), .hg_reset(hg_reset),
        .lg_reset(lg_reset), .track(track), .armed(armed), .evt_count(evt_count),
        .ovf(ovf), .slot_valid(slot_valid), .slot_range(slot_range), .slot_stamp(slot_stamp)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: at each hold (track falling) compare the slot filled by that event.
    always @(negedge clk) begin
        if (trk_prev && !track) begin
            if (sb_q.size() == 0) begin
                chk("R3", "unexpected hold, queue empty", 1, 0);
            end else begin
                exp_t it;
                it = sb_q.pop_front();
                chk("R3", "slot valid", int'(slot_valid[it.idx]), 1);
                chk("R2", "slot stamp", int'(slot_stamp[it.idx*12 +: 12]), int'(it.stamp));
                chk("R4", "slot range", int'(slot_range[it.idx]), int'(it.rng));
            end
        end
        trk_prev = track;
    end

    function automatic int sat(int v);
        return (v >= 4095) ? 4095 : v + 1;
    endfunction

    task automatic strobe(bit chk_hg);
        @(negedge clk);
        bunch_strobe = 1'b1;
        @(negedge clk);
        bunch_strobe = 1'b0;
        bc = sat(bc);
        if (chk_hg) begin
            chk("R6", "hg pulse after strobe", int'(hg_reset), 1);
            @(negedge clk);
            chk("R6", "hg pulse one cycle", int'(hg_reset), 0);
        end
    endtask

    task automatic tstart();
        @(negedge clk);
        train_start = 1'b1;
        @(negedge clk);
        train_start = 1'b0;
        bc = 0;
        exp_cnt = 0;
        exp_idx = 0;
    endtask

    // Full event: trigger, optional range pulse at cycle d, optional coincident strobe.
    task automatic run_event(int d, bit co, bit timing);
        exp_t it;
        @(negedge clk);
        event_cmp = 1'b1;
        if (d == 0) range_cmp = 1'b1;
        if (co) bunch_strobe = 1'b1;
        it.idx   = exp_idx;
        it.stamp = 12'(bc);
        it.rng   = (d >= 0 && d <= RW);
        sb_q.push_back(it);
        exp_idx++;
        exp_cnt++;
        if (co) bc = sat(bc);
        for (int j = 0; j <= 55; j++) begin
            @(negedge clk);
            if (j == 0) begin
                range_cmp = 1'b0;
                if (co) begin
                    bunch_strobe = 1'b0;
                    chk("R6", "no hg pulse on trigger+strobe", int'(hg_reset), 0);
                end
                chk("R3", "not armed after trigger", int'(armed), 0);
            end
            if (j == 1) event_cmp = 1'b0;
            if (d > 0 && j == d - 1) range_cmp = 1'b1;
            if (d > 0 && j == d) range_cmp = 1'b0;
            if (j == 20) event_cmp = 1'b1;
            if (j == 21) event_cmp = 1'b0;
            if (j == 25) chk("R8", "busy edge not counted", int'(evt_count), exp_cnt);
            if (timing) begin
                if (j == TRK - 1) chk("R5", "track low before delay", int'(track), 0);
                if (j == TRK)     chk("R5", "track rises", int'(track), 1);
                if (j == HLD - 1) chk("R5", "track high before hold", int'(track), 1);
                if (j == HLD)     chk("R5", "track falls at hold", int'(track), 0);
                if (j == 30)      chk("R6", "no hg during event", int'(hg_reset), 0);
            end
        end
        chk("R7", "lg low while waiting for strobe", int'(lg_reset), 0);
        @(negedge clk);
        bunch_strobe = 1'b1;
        @(negedge clk);
        bunch_strobe = 1'b0;
        bc = sat(bc);
        chk("R7", "lg reset after strobe", int'(lg_reset), 1);
        chk("R7", "hg reset with lg reset", int'(hg_reset), 1);
        repeat (RL - 1) @(negedge clk);
        chk("R7", "lg reset last cycle", int'(lg_reset), 1);
        @(negedge clk);
        chk("R7", "re-armed", int'(armed), 1);
        chk("R7", "lg reset released", int'(lg_reset), 0);
        chk("R3", "event count", int'(evt_count), exp_cnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "lg in reset", int'(lg_reset), 1);
        chk("R1", "hg in reset", int'(hg_reset), 1);
        chk("R1", "track in reset", int'(track), 0);
        chk("R1", "armed in reset", int'(armed), 0);
        chk("R1", "count/ovf/valid in reset", int'({evt_count, ovf, slot_valid}), 0);
        rst = 1'b0;
        repeat (RL - 1) @(negedge clk);
        chk("R1", "startup lg still high", int'(lg_reset), 1);
        @(negedge clk);
        chk("R1", "armed after startup", int'(armed), 1);
        chk("R1", "startup lg released", int'(lg_reset), 0);

        tstart();
        strobe(1); strobe(1); strobe(1);

        run_event(0, 0, 1);          // range with trigger
        strobe(1);
        run_event(3, 0, 0);          // range inside window
        run_event(RW, 0, 0);         // range at last window cycle
        strobe(0); strobe(0);
        run_event(RW + 1, 0, 0);     // range too late
        chk("R3", "all slots valid", int'(slot_valid), 15);

        // Trigger with all slots full
        begin
            logic [11:0] s3;
            s3 = slot_stamp[47:36];
            @(negedge clk);
            event_cmp = 1'b1;
            exp_cnt++;
            @(negedge clk);
            event_cmp = 1'b0;
            chk("R9", "overflow set", int'(ovf), 1);
            chk("R9", "no sequence on full", int'(armed), 1);
            chk("R9", "count still increments", int'(evt_count), exp_cnt);
            repeat (TRK + 2) @(negedge clk);
            chk("R9", "no track on full", int'(track), 0);
            chk("R9", "slot 3 unchanged", int'(slot_stamp[47:36]), int'(s3));
            chk("R9", "overflow sticky", int'(ovf), 1);
        end

        tstart();
        chk("R10", "valid cleared", int'(slot_valid), 0);
        chk("R10", "count cleared", int'(evt_count), 0);
        chk("R10", "ovf cleared", int'(ovf), 0);
        strobe(0); strobe(0);
        run_event(-1, 1, 1);         // trigger coincident with strobe, stamp 2
        run_event(-1, 0, 0);         // next stamp must be 4 (3 after coincidence, +1 wait strobe)

        tstart();
        for (int k = 0; k < 4100; k++) begin
            @(negedge clk); bunch_strobe = 1'b1;
            @(negedge clk); bunch_strobe = 1'b0;
            bc = sat(bc);
        end
        run_event(2, 0, 0);          // stamp saturated at 4095
        chk("R2", "queue drained", sb_q.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule